// File: doc/BRIEF.md
# Memory Access Port Bridge

This block is the memory access port that sits behind a debug port. The debug port hands it one register access at a time: a bank field, a two-bit scan address, a read/write flag and 32 bits of data. The block answers each access with a one-cycle acknowledge that carries a response code and read data. Three registers are implemented: a control/status word, a transfer address and a data window. A fourth, read-only word identifies the port.

Touching the data window is the only way to reach memory. Each such access launches one 32-bit transfer on a simple single-transfer master port, at the address held in the transfer address register. Transfers are posted. The acknowledge goes back at once. While the transfer is outstanding, every access except one to the status word is refused with WAIT. A bus error latches a sticky flag, and while that flag is set, data window accesses are refused with FAULT.

Top module: `mem_ap_bridge`

## Requirements
- R1: After reset, rsp_ack and bus_valid are low. The transfer address reads 0, the status word reads 0, and the first data window read returns 0.
- R2: A write to offset 0x04 stores the 32-bit bus address. A read of 0x04 returns the stored value.
- R3: The register offset is {req_bank[3:0], req_a[1:0], 2'b00}. Registers respond only to a full match, so bank 1 with scan address 1 (offset 0x14) does not reach the transfer address register.
- R4: A read of offset 0xFC returns the ID_VALUE parameter. Writes to 0xFC have no effect.
- R5: An accepted access to offset 0x0C answers OK and starts exactly one bus transfer at the held address. A write carries req_wdata on bus_wdata. A read returns the data of the most recent error-free bus read (0 after reset), so the value fetched by one read is returned by the next.
- R6: While a transfer is outstanding, an access to any offset other than 0x00 is answered WAIT (code 2'b01) and has no effect. A read of 0x00 in that time returns bit 7 set.
- R7: A transfer ended with bus_error sets bit 1 of offset 0x00. While that bit is set, an access to 0x0C is answered FAULT (code 2'b10) and starts no transfer. Writing 1 to bit 1 of 0x00 clears it.
- R8: An access to an unimplemented offset is answered OK. Reads return 0 and writes have no effect.
- R9: rsp_ack is a one-cycle pulse in the cycle after req_valid is taken, with code OK = 2'b00. bus_valid stays high, with address, direction and data stable, until bus_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until rsp_ack |
| req_bank | input | 4 | Register bank bits, offset [7:4] |
| req_a | input | 2 | Scan address bits, offset [3:2] |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_ack | output | 1 | Access complete, one-cycle pulse |
| rsp_resp | output | 2 | 00 OK, 01 WAIT, 10 FAULT |
| rsp_rdata | output | 32 | Read data, valid with rsp_ack |
| bus_valid | output | 1 | Transfer request |
| bus_addr | output | 32 | Transfer address |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Transfer write data |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_error | input | 1 | Error response, valid with bus_ready |

## Verification
The assertions assume that the debug port holds req_valid, with its fields unchanged, until it sees rsp_ack, and then lowers req_valid in the acknowledge cycle. They also assume that bus_ready is raised only while bus_valid is high. The bench drives all inputs on the falling edge. It drops the request in the same half-cycle in which it sees the acknowledge. Its memory model raises bus_ready only for a pending transfer, after a chosen latency, and returns an error for addresses whose top nibble is F.

// File: rtl/mem_ap_pkg.sv
package mem_ap_pkg;
  localparam int AP_BANK_W = 4;
  localparam int AP_SCAN_W = 2;
  localparam int CSW_BUSY_BIT = 7;
  localparam int CSW_ERR_BIT  = 1;

  typedef enum logic [1:0] {
    RESP_OK    = 2'b00,
    RESP_WAIT  = 2'b01,
    RESP_FAULT = 2'b10
  } ap_resp_e;

  typedef enum logic [2:0] {
    SEL_CSW,
    SEL_TAR,
    SEL_DRW,
    SEL_IDR,
    SEL_NONE
  } ap_sel_e;
endpackage

// File: rtl/mem_ap_rst_sync.sv
module mem_ap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/mem_ap_decode.sv
module mem_ap_decode
  import mem_ap_pkg::*;
(
  input  logic [AP_BANK_W-1:0] bank,
  input  logic [AP_SCAN_W-1:0] scan,
  output ap_sel_e              sel
);
  logic [7:0] offset;

  assign offset = {bank, scan, 2'b00};

  always_comb begin
    case (offset)
      8'h00:   sel = SEL_CSW;
      8'h04:   sel = SEL_TAR;
      8'h0C:   sel = SEL_DRW;
      8'hFC:   sel = SEL_IDR;
      default: sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/mem_ap_bus_seq.sv
module mem_ap_bus_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_write,
  input  logic [DATA_W-1:0] start_wdata,
  output logic              busy,
  output logic              done_err,
  output logic              done_rd_ok,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic              bus_error
);
  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              finish;

  assign finish = valid_q & bus_ready;

  always_comb begin
    valid_d = valid_q;
    if (start)       valid_d = 1'b1;
    else if (finish) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      valid_q <= valid_d;
      if (start) begin
        addr_q  <= start_addr;
        write_q <= start_write;
        wdata_q <= start_wdata;
      end
    end
  end

  assign busy       = valid_q;
  assign done_err   = finish & bus_error;
  assign done_rd_ok = finish & ~bus_error & ~write_q;
  assign bus_valid  = valid_q;
  assign bus_addr   = addr_q;
  assign bus_write  = write_q;
  assign bus_wdata  = wdata_q;
endmodule

// File: rtl/mem_ap_bridge.sv
module mem_ap_bridge
  import mem_ap_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h1A47_0C35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [AP_BANK_W-1:0] req_bank,
  input  logic [AP_SCAN_W-1:0] req_a,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_ack,
  output logic [1:0]           rsp_resp,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 bus_valid,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic                 bus_write,
  output logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_ready,
  input  logic [DATA_W-1:0]    bus_rdata,
  input  logic                 bus_error
);
  logic              rst_q_n;
  ap_sel_e           sel;
  logic              accept, busy, start, err_clr, done_err, done_rd_ok;
  logic              ack_q, ack_d;
  ap_resp_e          resp_q, resp_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [ADDR_W-1:0] tar_q, tar_d;
  logic              sticky_q, sticky_d;
  logic [DATA_W-1:0] last_q;

  mem_ap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n)
  );

  mem_ap_decode u_dec (
    .bank(req_bank), .scan(req_a), .sel(sel)
  );

  mem_ap_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_q_n), .start(start), .start_addr(tar_q),
    .start_write(req_write), .start_wdata(req_wdata), .busy(busy),
    .done_err(done_err), .done_rd_ok(done_rd_ok),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_error(bus_error)
  );

  assign accept = req_valid & ~ack_q;

  always_comb begin
    ack_d   = accept;
    resp_d  = RESP_OK;
    rdata_d = '0;
    tar_d   = tar_q;
    err_clr = 1'b0;
    start   = 1'b0;
    if (accept) begin
      if (sel == SEL_CSW) begin
        if (req_write) begin
          err_clr = req_wdata[CSW_ERR_BIT];
        end else begin
          rdata_d[CSW_BUSY_BIT] = busy;
          rdata_d[CSW_ERR_BIT]  = sticky_q;
        end
      end else if (busy) begin
        resp_d = RESP_WAIT;
      end else begin
        case (sel)
          SEL_TAR: begin
            if (req_write) tar_d   = req_wdata[ADDR_W-1:0];
            else           rdata_d = DATA_W'(tar_q);
          end
          SEL_DRW: begin
            if (sticky_q) begin
              resp_d = RESP_FAULT;
            end else begin
              start = 1'b1;
              if (!req_write) rdata_d = last_q;
            end
          end
          SEL_IDR: begin
            if (!req_write) rdata_d = ID_VALUE;
          end
          default: ;
        endcase
      end
    end
    sticky_d = (sticky_q & ~err_clr) | done_err;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ack_q    <= 1'b0;
      resp_q   <= RESP_OK;
      rdata_q  <= '0;
      tar_q    <= '0;
      sticky_q <= 1'b0;
      last_q   <= '0;
    end else begin
      ack_q    <= ack_d;
      sticky_q <= sticky_d;
      tar_q    <= tar_d;
      if (accept) begin
        resp_q  <= resp_d;
        rdata_q <= rdata_d;
      end
      if (done_rd_ok) last_q <= bus_rdata;
    end
  end

  assign rsp_ack   = ack_q;
  assign rsp_resp  = resp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/mem_ap_bridge_chk.sv
module mem_ap_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_ack,
  input logic [1:0]        rsp_resp,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready
);
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  p_ack_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> $past(req_valid));

  p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_write) && $stable(bus_wdata)));

  p_wait_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && rsp_resp == 2'b01) |-> $past(bus_valid));

  p_start_with_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> (rsp_ack && rsp_resp == 2'b00));

  p_fault_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack && rsp_resp == 2'b10) |-> !bus_valid);

  p_resp_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> (rsp_resp != 2'b11));
endmodule

bind mem_ap_bridge mem_ap_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_ack(rsp_ack),
  .rsp_resp(rsp_resp), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/mem_ap_bridge_test.sv
`timescale 1ns/1ps
module mem_ap_bridge_test;
  localparam logic [31:0] ID = 32'h1A47_0C35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_bank = '0;
  logic [1:0] req_a = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ack, bus_valid, bus_write;
  logic [1:0] rsp_resp;
  logic [31:0] rsp_rdata, bus_addr, bus_wdata;
  logic bus_ready = 1'b0, bus_error = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2.5 clk = ~clk;

  mem_ap_bridge uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank(req_bank),
    .req_a(req_a), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_resp(rsp_resp), .rsp_rdata(rsp_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_error(bus_error)
  );

  int checks = 0, fails = 0, cyc = 0, lat = 2, wcnt = 0;
  logic [31:0] mem [16];
  bit done_flag = 0;

  task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory slave: ready after lat cycles, error on top nibble F
  always @(negedge clk) begin
    if (bus_valid && !bus_ready) begin
      if (wcnt >= lat) begin
        bus_ready <= 1'b1;
        bus_rdata <= mem[bus_addr[5:2]];
        bus_error <= (bus_addr[31:28] == 4'hF);
      end else wcnt++;
    end else begin
      bus_ready <= 1'b0;
      bus_error <= 1'b0;
      wcnt = 0;
    end
  end
  always @(posedge clk)
    if (bus_valid && bus_ready && bus_write && !bus_error) mem[bus_addr[5:2]] <= bus_wdata;

  // behavioural reference model
  logic m_ack, m_bv, m_bw, m_sticky;
  logic [1:0] m_resp;
  logic [31:0] m_rdata, m_tar, m_last, m_ba, m_bd;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ack <= 0; m_bv <= 0; m_bw <= 0; m_sticky <= 0; m_resp <= 0;
      m_rdata <= 0; m_tar <= 0; m_last <= 0; m_ba <= 0; m_bd <= 0;
    end else begin
      automatic int off = {req_bank, req_a, 2'b00};
      automatic bit take = req_valid && !m_ack;
      automatic bit clr = 0;
      m_ack <= take;
      if (m_bv && bus_ready) begin
        m_bv <= 0;
        if (!bus_error && !m_bw) m_last <= bus_rdata;
      end
      if (take) begin
        m_resp <= 2'b00; m_rdata <= 0;
        if (off == 0) begin
          if (req_write) clr = req_wdata[1];
          else m_rdata <= {24'b0, m_bv, 5'b0, m_sticky, 1'b0};
        end else if (m_bv) m_resp <= 2'b01;
        else if (off == 4) begin
          if (req_write) m_tar <= req_wdata; else m_rdata <= m_tar;
        end else if (off == 12) begin
          if (m_sticky) m_resp <= 2'b10;
          else begin
            m_bv <= 1; m_ba <= m_tar; m_bw <= req_write; m_bd <= req_wdata;
            if (!req_write) m_rdata <= m_last;
          end
        end else if (off == 252 && !req_write) m_rdata <= ID;
      end
      m_sticky <= (m_sticky && !clr) || (m_bv && bus_ready && bus_error);
    end
  end

  always @(negedge clk) if (rst_n && !done_flag) begin
    check("R9 model ack", rsp_ack === m_ack, {31'b0, rsp_ack}, {31'b0, m_ack});
    if (m_ack) begin
      check("R9 model resp", rsp_resp === m_resp, {30'b0, rsp_resp}, {30'b0, m_resp});
      check("R5 model rdata", rsp_rdata === m_rdata, rsp_rdata, m_rdata);
    end
    check("R9 model bus_valid", bus_valid === m_bv, {31'b0, bus_valid}, {31'b0, m_bv});
    if (m_bv) begin
      check("R5 model bus_addr", bus_addr === m_ba, bus_addr, m_ba);
      check("R5 model bus_write", bus_write === m_bw, {31'b0, bus_write}, {31'b0, m_bw});
      check("R5 model bus_wdata", bus_wdata === m_bd, bus_wdata, m_bd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic acc(input [3:0] b, input [1:0] a, input bit wr, input [31:0] d,
                     output [1:0] r, output [31:0] q);
    @(negedge clk);
    req_valid = 1; req_bank = b; req_a = a; req_write = wr; req_wdata = d;
    forever begin
      @(negedge clk);
      if (rsp_ack) break;
    end
    r = rsp_resp; q = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic wait_idle();
    logic [1:0] r; logic [31:0] q;
    for (int i = 0; i < 50; i++) begin
      acc(0, 0, 0, 0, r, q);
      if (!q[7]) break;
    end
  endtask

  initial begin
    logic [1:0] r; logic [31:0] q;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 ack idle", rsp_ack === 0, {31'b0, rsp_ack}, 0);
    check("R1 bus idle", bus_valid === 0, {31'b0, bus_valid}, 0);
    acc(0, 1, 0, 0, r, q); check("R1 tar reset", q === 0, q, 0);
    acc(0, 0, 0, 0, r, q); check("R1 status reset", q === 0, q, 0);
    acc(15, 3, 0, 0, r, q); check("R4 id read", q === ID, q, ID);
    acc(15, 3, 1, 32'h1111, r, q);
    acc(15, 3, 0, 0, r, q); check("R4 id write ignored", q === ID, q, ID);
    acc(0, 1, 1, 32'h10, r, q); check("R2 tar write ok", r === 2'b00, {30'b0, r}, 0);
    acc(0, 1, 0, 0, r, q); check("R2 tar read", q === 32'h10, q, 32'h10);
    acc(1, 1, 1, 32'h55, r, q); check("R3 bank1 ok", r === 2'b00, {30'b0, r}, 0);
    acc(0, 1, 0, 0, r, q); check("R3 tar untouched", q === 32'h10, q, 32'h10);
    acc(1, 1, 0, 0, r, q); check("R3 bank1 reads 0", q === 0, q, 0);
    acc(0, 2, 1, 32'h77, r, q);
    acc(0, 2, 0, 0, r, q); check("R8 unimpl read 0", q === 0 && r === 2'b00, q, 0);
    lat = 5;
    acc(0, 3, 1, 32'hA5A5A5A5, r, q); check("R5 drw write ok", r === 2'b00, {30'b0, r}, 0);
    acc(0, 0, 0, 0, r, q); check("R6 busy bit", q[7] === 1'b1, q, 32'h80);
    acc(0, 1, 1, 32'h20, r, q); check("R6 tar wait", r === 2'b01, {30'b0, r}, 1);
    wait_idle();
    acc(0, 1, 0, 0, r, q); check("R6 tar unchanged", q === 32'h10, q, 32'h10);
    acc(0, 3, 0, 0, r, q); check("R5 first read returns reset value", q === 0, q, 0);
    wait_idle();
    acc(0, 3, 0, 0, r, q); check("R5 posted read data", q === 32'hA5A5A5A5, q, 32'hA5A5A5A5);
    wait_idle();
    acc(0, 1, 1, 32'hF000_0000, r, q);
    acc(0, 3, 1, 32'h99, r, q);
    wait_idle();
    acc(0, 0, 0, 0, r, q); check("R7 sticky set", q === 32'h2, q, 32'h2);
    acc(0, 3, 0, 0, r, q); check("R7 fault", r === 2'b10, {30'b0, r}, 2);
    check("R7 no transfer", bus_valid === 0, {31'b0, bus_valid}, 0);
    acc(0, 0, 1, 32'h2, r, q);
    acc(0, 0, 0, 0, r, q); check("R7 sticky cleared", q === 0, q, 0);
    lat = 0;
    acc(0, 1, 1, 32'h8, r, q);
    acc(0, 3, 1, 32'h1234, r, q);
    wait_idle();
    acc(0, 3, 0, 0, r, q); check("R5 prior read data", q === 32'hA5A5A5A5, q, 32'hA5A5A5A5);
    wait_idle();
    acc(0, 3, 0, 0, r, q); check("R5 zero latency read", q === 32'h1234, q, 32'h1234);
    repeat (5) @(negedge clk);
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule